// File: doc/BRIEF.md
# DRAM Interface Reset Sequencer

This block sits between the reset input of a memory buffer and the DRAM pins it drives. The reset input is active low and arrives with no timing relation to the local clock. It may land at any moment, including partway through a DRAM command. When it does, the sequencer puts the DRAM side into a defined safe state. The clock-enable pin is pulled low on a purely combinational path from the reset input. The DRAM clock keeps running with full-width phases for a hold interval of `HOLD_CYC` local clock cycles, counted on the local clock, which never stops. After that interval the DRAM clock may be stopped on request. The sequencer also clears a small bank of sticky error-log words.

On release, the reset edge passes through a two-stage synchronizer. The DRAM clock comes back first. Only after that is the command side released through `cmd_rst_n`, and clock-enable then follows the command side's request one cycle later. Error bits collect by OR into one of `LOG_DEPTH` words, each `LOG_W` bits wide. They are written only while the command side is released, and they can be read back at any time through a combinational read port.

Top module: `dram_rst_seq`

## Requirements
- R1: Whenever `rst_n` is low, `dram_cke` is low, with no clock edge needed for it to fall.
- R2: Whenever `rst_n` is low, every error-log word reads back as zero, with no clock edge needed.
- R3: For the first `HOLD_CYC` rising `clk` edges after `rst_n` falls, `dram_ck` follows `clk` with full high and low phases. The gate that controls it changes only on falling `clk` edges.
- R4: `hold_done` goes high right after the `HOLD_CYC`-th rising edge after `rst_n` falls. `dram_ck` stops, held low, only from the falling edge that follows a rising edge at which `hold_done` is already high and `ck_stop_req` is high.
- R5: While reset is asserted with `ck_stop_req` low, `dram_ck` keeps toggling for as long as reset lasts.
- R6: After `rst_n` rises, the release takes effect at the second rising edge. `dram_ck` resumes from the falling edge after that second edge. `cmd_rst_n` goes high after the third rising edge, and `hold_done` is low by then.
- R7: `dram_cke` takes the value of `cke_req` one rising edge after `cmd_rst_n` is high, and stays low before that.
- R8: With `log_wr` high and `cmd_rst_n` high at a rising edge, `log_wr_bits` is ORed into word `log_wr_idx`, and the other words are unchanged. A write while `cmd_rst_n` is low is ignored. `log_rd_bits` shows word `log_rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, keeps running during reset |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_req | input | 1 | Clock-enable level requested by the command side |
| ck_stop_req | input | 1 | Request to stop the DRAM clock once the hold interval is over |
| log_wr | input | 1 | Error-log write strobe |
| log_wr_idx | input | IDX_W | Error-log word to write |
| log_wr_bits | input | LOG_W | Error bits to OR into that word |
| log_rd_idx | input | IDX_W | Error-log word to read |
| log_rd_bits | output | LOG_W | Contents of the selected word |
| dram_ck | output | 1 | Gated DRAM clock |
| dram_cke | output | 1 | DRAM clock-enable |
| cmd_rst_n | output | 1 | Active-low release for the command logic |
| hold_done | output | 1 | The hold interval has elapsed in the current reset |

## Verification
The bench looks at `dram_cke` and the log read port a fraction of a nanosecond after `rst_n` falls, before any clock edge. A design that waited for a clock edge there would show a stale high clock-enable or stale log bits. It counts the DRAM clock pulses after reset assertion: one pulse too few means the hold counter is off by one, and one pulse too many means the gate came late. It also checks that the clock keeps running when no stop is requested. On release, it samples each cycle to catch a command release that overtakes the DRAM clock, and a clock-enable that leaks high before the command side is free. It also issues a log write inside the release window, which a design with a wrong write guard would record.

// File: rtl/dram_rst_seq.sv
module dram_rst_seq #(
  parameter int HOLD_CYC  = 4,
  parameter int LOG_DEPTH = 4,
  parameter int LOG_W     = 8,
  localparam int IDX_W    = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_req,
  input  logic             ck_stop_req,
  input  logic             log_wr,
  input  logic [IDX_W-1:0] log_wr_idx,
  input  logic [LOG_W-1:0] log_wr_bits,
  input  logic [IDX_W-1:0] log_rd_idx,
  output logic [LOG_W-1:0] log_rd_bits,
  output logic             dram_ck,
  output logic             dram_cke,
  output logic             cmd_rst_n,
  output logic             hold_done
);

  logic [1:0]          sync_q;
  logic                in_rst;
  logic [HOLD_CYC-1:0] hold_sr;
  logic                ck_en_q;
  logic                rel_q;
  logic                cke_q;
  logic [LOG_W-1:0]    log_q [LOG_DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};

  assign in_rst = ~sync_q[1];

  // Hold timer runs on the free clock while reset is held; cleared once released.
  generate
    if (HOLD_CYC == 1) begin : g_hold_one
      always_ff @(posedge clk)
        hold_sr <= in_rst;
    end else begin : g_hold_chain
      always_ff @(posedge clk)
        hold_sr <= in_rst ? {hold_sr[HOLD_CYC-2:0], 1'b1} : '0;
    end
  endgenerate

  assign hold_done = hold_sr[HOLD_CYC-1];

  // Gate enable moves only while clk is low, so no runt pulse can be formed.
  always_ff @(negedge clk)
    ck_en_q <= !(in_rst && hold_done && ck_stop_req);

  assign dram_ck = clk & ck_en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= sync_q[1] & ck_en_q;

  assign cmd_rst_n = rel_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= rel_q & cke_req;

  assign dram_cke = rst_n & cke_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < LOG_DEPTH; i++) log_q[i] <= '0;
    end else if (log_wr && rel_q && (int'(log_wr_idx) < LOG_DEPTH)) begin
      log_q[log_wr_idx] <= log_q[log_wr_idx] | log_wr_bits;
    end

  assign log_rd_bits = (int'(log_rd_idx) < LOG_DEPTH) ? log_q[log_rd_idx] : '0;

  AST_CKE_LOW_IN_RESET: assert property (@(posedge clk) !rst_n |-> !dram_cke); // R1
  AST_LOG_CLEAR_IN_RESET: assert property (@(posedge clk) !rst_n |-> (log_rd_bits == '0)); // R2
  AST_HOLD_STAYS_DONE: assert property (@(posedge clk) disable iff (rst_n) hold_done |=> hold_done); // R4
  AST_GATE_ONLY_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ck_en_q |-> hold_done); // R4
  AST_CMD_AFTER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) cmd_rst_n |-> ck_en_q); // R6
  AST_CKE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n) dram_cke |-> cmd_rst_n); // R7

endmodule

// File: tb/test_dram_rst_seq.sv
`timescale 1ns/1ps
module test_dram_rst_seq;
  localparam int HOLD_CYC = 4;
  localparam int DEPTH    = 4;
  localparam int W        = 8;
  localparam int IW       = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_req = 1'b1;
  logic ck_stop_req = 1'b1;
  logic log_wr = 1'b0;
  logic [IW-1:0] log_wr_idx = '0;
  logic [W-1:0]  log_wr_bits = '0;
  logic [IW-1:0] log_rd_idx = '0;
  logic [W-1:0]  log_rd_bits;
  logic dram_ck, dram_cke, cmd_rst_n, hold_done;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_rst_seq #(.HOLD_CYC(HOLD_CYC), .LOG_DEPTH(DEPTH), .LOG_W(W)) i_dram_rst_seq (
    .clk(clk), .rst_n(rst_n), .cke_req(cke_req), .ck_stop_req(ck_stop_req),
    .log_wr(log_wr), .log_wr_idx(log_wr_idx), .log_wr_bits(log_wr_bits),
    .log_rd_idx(log_rd_idx), .log_rd_bits(log_rd_bits),
    .dram_ck(dram_ck), .dram_cke(dram_cke), .cmd_rst_n(cmd_rst_n), .hold_done(hold_done)
  );

  // {wr, wr_idx[1:0], wr_bits[7:0], rd_idx[1:0], expected[7:0]}
  localparam logic [20:0] VEC [7] = '{
    {1'b1, 2'd0, 8'h01, 2'd0, 8'h01},
    {1'b1, 2'd0, 8'h10, 2'd0, 8'h11},
    {1'b1, 2'd2, 8'hA0, 2'd2, 8'hA0},
    {1'b0, 2'd0, 8'hFF, 2'd0, 8'h11},
    {1'b1, 2'd3, 8'h0F, 2'd3, 8'h0F},
    {1'b1, 2'd3, 8'hF0, 2'd3, 8'hFF},
    {1'b0, 2'd1, 8'h55, 2'd1, 8'h00}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic release_and_check();
    rst_n = 1'b1;
    step();
    check(cmd_rst_n == 1'b0, "R6 cmd held after first edge", cmd_rst_n, 0);
    step();
    check(cmd_rst_n == 1'b0, "R6 cmd held after second edge", cmd_rst_n, 0);
    step();
    check(cmd_rst_n == 1'b1, "R6 cmd released after third edge", cmd_rst_n, 1);
    check(dram_ck == 1'b1, "R6 dram clock running before cmd release", dram_ck, 1);
    check(hold_done == 1'b0, "R6 hold flag cleared", hold_done, 0);
    check(dram_cke == 1'b0, "R7 cke still low at release", dram_cke, 0);
    step();
    check(dram_cke == cke_req, "R7 cke follows request", dram_cke, cke_req);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 10; k++) step();
    check(dram_cke == 1'b0, "R1 cke low at power-up", dram_cke, 0);
    check(cmd_rst_n == 1'b0, "R6 cmd held at power-up", cmd_rst_n, 0);
    check(dram_ck == 1'b0, "R4 clock stopped after hold", dram_ck, 0);
    check(log_rd_bits == 8'h00, "R2 log zero at power-up", log_rd_bits, 0);

    // release with a log write inside the window, which must be ignored
    rst_n = 1'b1;
    step();
    log_wr = 1'b1; log_wr_idx = 2'd1; log_wr_bits = 8'h5A;
    step();
    log_wr = 1'b0;
    check(cmd_rst_n == 1'b0, "R6 cmd held after second edge", cmd_rst_n, 0);
    check(dram_ck == 1'b0, "R6 clock still gated at second edge", dram_ck, 0);
    step();
    check(cmd_rst_n == 1'b1, "R6 cmd released after third edge", cmd_rst_n, 1);
    check(dram_ck == 1'b1, "R6 clock resumed", dram_ck, 1);
    check(dram_cke == 1'b0, "R7 cke low at release", dram_cke, 0);
    step();
    check(dram_cke == 1'b1, "R7 cke follows request", dram_cke, 1);
    log_rd_idx = 2'd1;
    #0.5;
    check(log_rd_bits == 8'h00, "R8 write ignored before release", log_rd_bits, 0);

    foreach (VEC[v]) begin
      log_wr = VEC[v][20]; log_wr_idx = VEC[v][19:18]; log_wr_bits = VEC[v][17:10];
      step();
      log_wr = 1'b0;
      log_rd_idx = VEC[v][9:8];
      #0.5;
      check(log_rd_bits == VEC[v][7:0], "R8 sticky log vector", log_rd_bits, VEC[v][7:0]);
    end

    cke_req = 1'b0;
    step();
    check(dram_cke == 1'b0, "R7 cke drops with request", dram_cke, 0);
    cke_req = 1'b1;
    step();
    check(dram_cke == 1'b1, "R7 cke rises with request", dram_cke, 1);

    // reset in the middle of activity, clock stop requested
    log_rd_idx = 2'd3;
    rst_n = 1'b0;
    #0.2;
    check(dram_cke == 1'b0, "R1 cke drops without clock edge", dram_cke, 0);
    check(log_rd_bits == 8'h00, "R2 log cleared without clock edge", log_rd_bits, 0);
    for (int k = 1; k <= HOLD_CYC; k++) begin
      step();
      check(dram_ck == 1'b1, "R3 full high phase during hold", dram_ck, 1);
      #2.5;
      check(dram_ck == 1'b0, "R3 full low phase during hold", dram_ck, 0);
      #(-0.0);
      check(hold_done == (k == HOLD_CYC), "R4 hold flag timing", hold_done, k == HOLD_CYC);
    end
    step();
    check(dram_ck == 1'b0, "R4 clock stopped after hold", dram_ck, 0);
    release_and_check();

    // reset with no stop request: clock keeps running
    ck_stop_req = 1'b0;
    step();
    rst_n = 1'b0;
    for (int k = 0; k < 3 * HOLD_CYC; k++) begin
      step();
      check(dram_ck == 1'b1, "R5 clock runs without stop request", dram_ck, 1);
    end
    ck_stop_req = 1'b1;
    step();
    check(dram_ck == 1'b0, "R4 late stop request gates clock", dram_ck, 0);
    release_and_check();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule